// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Redirect Control

This block predicts the next fetch address for the fetch stage of a pipelined core. Each cycle the fetch stage may present its current PC. The block looks the PC up in a direct-mapped table of branches that it has seen taken. On a match it returns the stored target as the next fetch PC, so a taken branch is followed before it is decoded. On no match it returns the sequential address PC+4.

Later in the pipeline each branch is resolved. The pipeline hands back the branch PC, the real direction, the real target, and what fetch saw for that branch: whether the lookup hit and which target it used. From this the block classifies the outcome and edits the table. It inserts taken branches that missed, deletes entries that steered fetch wrongly, and retargets entries whose target changed. When the path fetch took was wrong, it raises a one-cycle flush together with the correct next PC. It also reports the outcome class and the penalty in cycles. The table contents sit in a synchronous read-first memory. The valid bits are reset flops.

Top module: `fetch_btb`

## Requirements
- R1: After reset every entry is invalid, and pred_valid, out_valid and flush are low. The first lookup of any PC after reset misses.
- R2: One cycle after fetch_valid is high, pred_valid is high. pred_hit is high when the entry at index PC[5:2] is valid and its stored tag equals PC[31:6]; pred_next_pc is then the stored target. pred_valid is low one cycle after fetch_valid is low.
- R3: On a valid lookup that misses, pred_hit is low and pred_next_pc is the looked-up PC plus 4.
- R4: A resolved branch that hit, was taken, and whose real target equals the predicted target gives class 1 and penalty 0, with no flush. Its entry is unchanged.
- R5: A resolved branch that hit but was not taken gives a flush with redirect_pc equal to its PC plus 4, class 2 and penalty 2. Its entry is made invalid, so a later lookup of that PC misses.
- R6: A resolved branch that hit and was taken to a target other than the predicted one gives a flush with redirect_pc equal to the real target, class 2 and penalty 2. The stored target is replaced.
- R7: A resolved branch that missed and was taken is written into the table with its tag and real target. It gives a flush with redirect_pc equal to the real target, class 3 and penalty 2.
- R8: A resolved branch that missed and was not taken gives class 0, penalty 0 and no flush. The table is left unchanged.
- R9: When a table write and a lookup fall on the same index in one cycle, the lookup result reflects the contents from before the write.
- R10: The resolve results (out_valid, flush, redirect_pc, out_class, out_penalty) appear one cycle after res_valid. flush is never high without out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_pc | input | 32 | PC being fetched |
| pred_valid | output | 1 | Lookup result is valid (one cycle after request) |
| pred_hit | output | 1 | Lookup matched a stored branch |
| pred_next_pc | output | 32 | Predicted next fetch PC |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Real direction of the branch |
| res_target | input | 32 | Real target of the branch |
| res_hit | input | 1 | The fetch lookup of this branch hit |
| res_pred_target | input | 32 | Target fetch used on that hit |
| out_valid | output | 1 | Resolve result is valid |
| flush | output | 1 | Kill the wrong-path fetch and restart at redirect_pc |
| redirect_pc | output | 32 | Correct next PC for the resolved branch |
| out_class | output | 2 | Outcome class: 0 miss not taken, 1 hit correct, 2 hit wrong, 3 miss taken |
| out_penalty | output | 2 | Penalty in cycles: 0 or 2 |

## Verification
Bad internal state in this block shows up at the ports in two places. A corrupted valid bit, tag or target changes pred_hit or pred_next_pc on the very next lookup of that index, one cycle after the request. A wrong resolve decision shows on flush, redirect_pc and out_class in the cycle after res_valid. A lost or misplaced table write shows up later, on the first following fetch of that branch or of an alias that shares its index. Heavy index aliasing and same-cycle lookups of the written index are therefore what expose write-path and read-ordering faults.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
  typedef enum logic [1:0] {
    CLS_SEQ_OK     = 2'd0,
    CLS_HIT_OK     = 2'd1,
    CLS_HIT_WRONG  = 2'd2,
    CLS_MISS_TAKEN = 2'd3
  } res_cls_e;

  localparam logic [1:0] PEN_NONE     = 2'd0;
  localparam logic [1:0] PEN_REDIRECT = 2'd2;
endpackage

// File: rtl/btb_store.sv
`timescale 1ns/1ps
module btb_store #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  parameter int TGT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ENT_W  = TAG_W + TGT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt,
  input  logic             wr_en,
  input  logic             wr_keep,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt
);
  logic [ENT_W-1:0]   mem [ENTRIES];
  logic [ENT_W-1:0]   rd_q;
  logic [ENTRIES-1:0] vld_q;
  logic               rd_vld_q;

  // Read-first synchronous memory: a same-cycle write is not seen by the read.
  always_ff @(posedge clk) begin
    if (wr_en && wr_keep) mem[wr_idx] <= {wr_tag, wr_tgt};
    rd_q <= mem[rd_idx];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst) vld_q[e] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(e))) vld_q[e] <= wr_keep;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld_q <= 1'b0;
    else     rd_vld_q <= vld_q[rd_idx];
  end

  assign rd_vld = rd_vld_q;
  assign rd_tag = rd_q[ENT_W-1:TGT_W];
  assign rd_tgt = rd_q[TGT_W-1:0];
endmodule

// File: rtl/btb_lookup.sv
`timescale 1ns/1ps
module btb_lookup #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_vld,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_tgt,
  output logic             pred_valid,
  output logic             pred_hit,
  output logic [PC_W-1:0]  pred_next_pc
);
  logic            fv_q;
  logic [PC_W-1:0] pc_q;

  assign rd_idx = fetch_pc[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      fv_q <= 1'b0;
      pc_q <= '0;
    end else begin
      fv_q <= fetch_valid;
      pc_q <= fetch_pc;
    end
  end

  assign pred_valid   = fv_q;
  assign pred_hit     = fv_q && rd_vld && (rd_tag == pc_q[PC_W-1:IDX_W+2]);
  assign pred_next_pc = pred_hit ? rd_tgt : pc_q + PC_W'(4);
endmodule

// File: rtl/btb_resolve.sv
`timescale 1ns/1ps
module btb_resolve
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  input  logic             res_hit,
  input  logic [PC_W-1:0]  res_pred_target,
  output logic             wr_en,
  output logic             wr_keep,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PC_W-1:0]  wr_tgt,
  output logic             out_valid,
  output logic             flush,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [1:0]       out_class,
  output logic [1:0]       out_penalty
);
  res_cls_e        cls;
  logic            wrong;
  logic [PC_W-1:0] next_pc;

  assign wr_idx = res_pc[IDX_W+1:2];
  assign wr_tag = res_pc[PC_W-1:IDX_W+2];
  assign wr_tgt = res_target;

  always_comb begin
    cls     = CLS_SEQ_OK;
    wrong   = 1'b0;
    wr_en   = 1'b0;
    wr_keep = 1'b0;
    next_pc = res_taken ? res_target : res_pc + PC_W'(4);
    if (res_hit) begin
      if (!res_taken) begin
        cls   = CLS_HIT_WRONG;
        wrong = 1'b1;
        wr_en = res_valid;
      end else if (res_target != res_pred_target) begin
        cls     = CLS_HIT_WRONG;
        wrong   = 1'b1;
        wr_en   = res_valid;
        wr_keep = 1'b1;
      end else begin
        cls = CLS_HIT_OK;
      end
    end else if (res_taken) begin
      cls     = CLS_MISS_TAKEN;
      wrong   = 1'b1;
      wr_en   = res_valid;
      wr_keep = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      flush       <= 1'b0;
      redirect_pc <= '0;
      out_class   <= 2'd0;
      out_penalty <= PEN_NONE;
    end else begin
      out_valid   <= res_valid;
      flush       <= res_valid && wrong;
      redirect_pc <= next_pc;
      out_class   <= cls;
      out_penalty <= wrong ? PEN_REDIRECT : PEN_NONE;
    end
  end
endmodule

// File: rtl/fetch_btb.sv
`timescale 1ns/1ps
module fetch_btb #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_hit,
  input  logic [PC_W-1:0] res_pred_target,
  output logic            out_valid,
  output logic            flush,
  output logic [PC_W-1:0] redirect_pc,
  output logic [1:0]      out_class,
  output logic [1:0]      out_penalty
);
  logic [IDX_W-1:0] rd_idx;
  logic             rd_vld;
  logic [TAG_W-1:0] rd_tag;
  logic [PC_W-1:0]  rd_tgt;
  logic             wr_en;
  logic             wr_keep;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [PC_W-1:0]  wr_tgt;

  btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(PC_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
    .wr_en(wr_en), .wr_keep(wr_keep), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_next_pc(pred_next_pc)
  );

  btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W)) u_resolve (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_hit(res_hit), .res_pred_target(res_pred_target),
    .wr_en(wr_en), .wr_keep(wr_keep), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt),
    .out_valid(out_valid), .flush(flush), .redirect_pc(redirect_pc),
    .out_class(out_class), .out_penalty(out_penalty)
  );
endmodule

// File: rtl/fetch_btb_checker.sv
`timescale 1ns/1ps
module fetch_btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_valid,
  input logic            pred_hit,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic            res_hit,
  input logic [PC_W-1:0] res_pred_target,
  input logic            out_valid,
  input logic            flush,
  input logic [PC_W-1:0] redirect_pc,
  input logic [1:0]      out_class,
  input logic [1:0]      out_penalty
);
  AST_FETCH_GIVES_PRED: assert property (@(posedge clk) disable iff (rst) fetch_valid |=> pred_valid); // R2
  AST_IDLE_NO_PRED: assert property (@(posedge clk) disable iff (rst) !fetch_valid |=> !pred_valid && !pred_hit); // R2
  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    pred_valid && !pred_hit |-> pred_next_pc == $past(fetch_pc) + PC_W'(4)); // R3
  AST_HIT_OK_QUIET: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_hit && res_taken && res_target == res_pred_target |=> out_valid && !flush && out_penalty == 2'd0 && out_class == 2'd1); // R4
  AST_HIT_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_hit && !res_taken |=> flush && redirect_pc == $past(res_pc) + PC_W'(4) && out_class == 2'd2 && out_penalty == 2'd2); // R5
  AST_HIT_RETARGET: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_hit && res_taken && res_target != res_pred_target |=> flush && redirect_pc == $past(res_target) && out_class == 2'd2); // R6
  AST_MISS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_hit && res_taken |=> flush && redirect_pc == $past(res_target) && out_class == 2'd3 && out_penalty == 2'd2); // R7
  AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_hit && !res_taken |=> out_valid && !flush && out_class == 2'd0); // R8
  AST_FLUSH_WITH_RESULT: assert property (@(posedge clk) disable iff (rst) flush |-> out_valid); // R10
  AST_RESULT_FOLLOWS_RES: assert property (@(posedge clk) disable iff (rst) !res_valid |=> !out_valid); // R10
endmodule

bind fetch_btb fetch_btb_checker #(.PC_W(PC_W)) u_chk (.*);

// File: tb/fetch_btb_test.sv
`timescale 1ns/1ps
module fetch_btb_test;
  localparam int ENTRIES = 16;
  localparam int IDX_W   = 4;
  localparam int TAG_W   = 32 - IDX_W - 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_valid, pred_hit;
  logic [31:0] pred_next_pc;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic        res_hit = 1'b0;
  logic [31:0] res_pred_target = '0;
  logic        out_valid, flush;
  logic [31:0] redirect_pc;
  logic [1:0]  out_class, out_penalty;

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural model of the table
  bit             m_v   [ENTRIES];
  logic [TAG_W-1:0] m_tag [ENTRIES];
  logic [31:0]    m_tgt [ENTRIES];
  bit             first_lookup = 1'b1;

  always #10 clk = ~clk;

  fetch_btb uut (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_hit(res_hit), .res_pred_target(res_pred_target),
    .out_valid(out_valid), .flush(flush), .redirect_pc(redirect_pc),
    .out_class(out_class), .out_penalty(out_penalty)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negedge: drives one cycle of stimulus, advances, compares.
  task automatic tick(input bit fv, input logic [31:0] fpc, input bit rv,
                      input logic [31:0] rpc, input bit rtk, input logic [31:0] rtg);
    int fi, ri;
    bit rh, e_ph, e_fl;
    logic [31:0] rpt, e_pn, e_rd;
    logic [1:0] e_cls, e_pen;
    string preq, rreq;
    fi  = int'(fpc[IDX_W+1:2]);
    ri  = int'(rpc[IDX_W+1:2]);
    rh  = m_v[ri] && (m_tag[ri] == rpc[31:IDX_W+2]);
    rpt = m_tgt[ri];
    fetch_valid = fv; fetch_pc = fpc;
    res_valid = rv; res_pc = rpc; res_taken = rtk; res_target = rtg;
    res_hit = rv && rh; res_pred_target = rpt;
    // lookup expectation from contents before any update this cycle
    e_ph = fv && m_v[fi] && (m_tag[fi] == fpc[31:IDX_W+2]);
    e_pn = e_ph ? m_tgt[fi] : fpc + 32'd4;
    preq = first_lookup ? "R1" : (e_ph ? "R2" : "R3");
    e_fl = 1'b0; e_rd = '0; e_cls = 2'd0; e_pen = 2'd0; rreq = "R10";
    if (rv) begin
      if (rh && !rtk) begin
        e_fl = 1'b1; e_rd = rpc + 32'd4; e_cls = 2'd2; e_pen = 2'd2; rreq = "R5";
        m_v[ri] = 1'b0;
      end else if (rh && rtg != rpt) begin
        e_fl = 1'b1; e_rd = rtg; e_cls = 2'd2; e_pen = 2'd2; rreq = "R6";
        m_tgt[ri] = rtg;
      end else if (rh) begin
        e_rd = rtg; e_cls = 2'd1; rreq = "R4";
      end else if (rtk) begin
        e_fl = 1'b1; e_rd = rtg; e_cls = 2'd3; e_pen = 2'd2; rreq = "R7";
        m_v[ri] = 1'b1; m_tag[ri] = rpc[31:IDX_W+2]; m_tgt[ri] = rtg;
      end else begin
        e_rd = rpc + 32'd4; e_cls = 2'd0; rreq = "R8";
      end
      if (e_fl && fv && fi == ri) preq = "R9";
    end
    if (fv) first_lookup = 1'b0;
    @(negedge clk);
    chk("R2", "pred_valid", 32'(pred_valid), 32'(fv));
    if (fv) begin
      chk(preq, "pred_hit", 32'(pred_hit), 32'(e_ph));
      chk(preq, "pred_next_pc", pred_next_pc, e_pn);
    end
    chk("R10", "out_valid", 32'(out_valid), 32'(rv));
    chk(rreq, "flush", 32'(flush), 32'(e_fl));
    if (rv) begin
      chk(rreq, "out_class", 32'(out_class), 32'(e_cls));
      chk(rreq, "out_penalty", 32'(out_penalty), 32'(e_pen));
      chk(rreq, "redirect_pc", redirect_pc, e_rd);
    end
  endtask

  function automatic logic [31:0] mkpc();
    logic [TAG_W-1:0] t;
    logic [IDX_W-1:0] i;
    t = TAG_W'(32'h100 + $urandom_range(0, 2));
    i = IDX_W'($urandom_range(0, 3));
    return {t, i, 2'b00};
  endfunction

  logic [31:0] A, B, C, T1, T2;
  logic [31:0] rp, fp, tg;
  bit          rv, fv, tk;
  int          ri;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "pred_valid after reset", 32'(pred_valid), 32'd0);
    chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "flush after reset", 32'(flush), 32'd0);

    A  = {26'h0000ABC, 4'd5, 2'b00};
    B  = {26'h0000ABD, 4'd6, 2'b00};
    C  = {26'h0000123, 4'd5, 2'b00};   // aliases A's index
    T1 = 32'h0004_0000;
    T2 = 32'h0008_1230;

    tick(1, A, 0, '0, 0, '0);          // R1: empty table misses
    tick(1, A, 1, A, 1, T1);           // R7 insert; same-cycle lookup old (R9)
    tick(1, A, 0, '0, 0, '0);          // R2 hit with T1
    tick(0, '0, 1, A, 1, T1);          // R4 correct hit
    tick(1, A, 1, A, 1, T2);           // R6 retarget (R9 old T1 seen)
    tick(1, A, 0, '0, 0, '0);          // R2 hit with T2
    tick(0, '0, 1, A, 0, '0);          // R5 delete
    tick(1, A, 0, '0, 0, '0);          // R5 entry gone: miss
    tick(1, B, 1, B, 0, '0);           // R8 no change
    tick(1, B, 0, '0, 0, '0);          // R8 still miss
    tick(0, '0, 1, A, 1, T1);          // R7
    tick(0, '0, 1, C, 1, T2);          // R7 alias replaces
    tick(1, A, 0, '0, 0, '0);          // A now misses
    tick(1, C, 0, '0, 0, '0);          // C hits T2

    for (int n = 0; n < 3000; n++) begin
      rp = mkpc();
      fp = ($urandom_range(0, 1) == 0) ? rp : mkpc();
      rv = $urandom_range(0, 3) != 0;
      fv = $urandom_range(0, 4) != 0;
      tk = $urandom_range(0, 1) == 1;
      tg = $urandom & 32'hFFFF_FFFC;
      ri = int'(rp[IDX_W+1:2]);
      if (m_v[ri] && m_tag[ri] == rp[31:IDX_W+2] && $urandom_range(0, 2) != 0) tg = m_tgt[ri];
      tick(fv, fp, rv, rp, tk, tg);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule